// File: doc/BRIEF.md
# Radix-2 Delay-Feedback Butterfly Stage

This block is one stage of a pipelined FFT built from delay-feedback stages. It accepts one complex sample per clock and keeps half a frame in a shift register that feeds back on itself. An external binary counter supplies a phase bit. While the bit is low, the block is in the fill phase: each incoming sample goes into the delay line, and the output is the sample that leaves the line. While the bit is high, the block is in the compute phase. It pairs each incoming sample b with the sample a that leaves the line. It sends a+b downstream and pushes a−b back into the line.

The differences written back during a compute phase leave the line during the following fill phase, while the next frame's first half enters. One delay line therefore serves as both the input buffer and the output buffer. The output is continuous once the first half frame has been absorbed. A parameter chooses between two output widths: full growth (one extra bit) or halving with rounding (same width as the input). Twiddle multiplication and output reordering belong to other blocks.

Top module: `rdf_butterfly`

## Requirements
- R1: When a valid sample arrives with phase low (fill), it enters the delay line and is the a operand exactly DEPTH valid cycles later.
- R2: When a valid sample b arrives with phase high (compute), out_re/out_im equal a+b for each component in that same cycle, where a is the sample leaving the delay line.
- R3: In the compute phase a−b is written into the delay line. It appears at the output, in order, during the next fill phase, DEPTH valid cycles later.
- R4: out_valid stays low during the fill phase of the first frame after reset. The first valid output appears on the valid input DEPTH cycles after the first input. It is asserted on every later valid input.
- R5: out_valid is never high in a cycle where in_valid is low.
- R6: A cycle with in_valid low leaves the delay line unchanged. Results after a stall equal those of the same data applied with no gap.
- R7: A synchronous reset empties the delay line to zero and clears the primed state. After reset, fill-phase outputs are invalid, and a compute-phase input b yields b.
- R8: With SCALE=1, every sum and difference v becomes (v+1) arithmetically shifted right by one. This rounds halves toward +infinity, and the output width equals W.
- R9: With SCALE=0, the output is W+1 bits wide and full-scale inputs give exact results with no wrap (for example, 127 − (−128) = 255 for W=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe; the line shifts only when high |
| phase | input | 1 | 0 = fill, 1 = compute; one bit of an external frame counter |
| in_re | input | W | Real part of input, signed |
| in_im | input | W | Imaginary part of input, signed |
| out_valid | output | 1 | Output sample strobe |
| out_re | output | OW | Real part of output, signed (OW = W+1, or W when SCALE=1) |
| out_im | output | OW | Imaginary part of output, signed |

## Verification
In every compute cycle the block sends a sum downstream and stores a difference, all in one cycle. In every fill cycle after the first frame, it drains an old difference while it captures a new sample. The stimulus runs frames back to back with no gaps, so both pairs of actions occur together throughout. The stored differences are then judged at the ports during the next fill phase, one line depth later, against values worked out by hand. A stall in the middle of a frame and a reset in the middle of a frame confirm that the shared line neither skips nor leaks a sample.

// File: rtl/rdf_butterfly.sv
module rdf_butterfly #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  parameter bit SCALE = 1'b0,
  localparam int OW = SCALE ? W : W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 phase,
  input  logic signed [W-1:0]  in_re,
  input  logic signed [W-1:0]  in_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  localparam int XW = W + 2;

  logic signed [OW-1:0] line_re [DEPTH];
  logic signed [OW-1:0] line_im [DEPTH];
  logic primed;

  logic signed [OW-1:0] head_re, head_im;
  logic signed [XW-1:0] a_re, a_im, b_re, b_im;
  logic signed [OW-1:0] sum_re, sum_im, dif_re, dif_im;

  function automatic logic signed [OW-1:0] fold(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] t;
    logic signed [XW-1:0] r;
    if (SCALE) begin
      t = v + $signed({{(XW-1){1'b0}}, 1'b1});
      r = t >>> 1;
      return r[OW-1:0];
    end
    return v[OW-1:0];
  endfunction

  assign head_re = line_re[DEPTH-1];
  assign head_im = line_im[DEPTH-1];

  assign a_re = $signed({{(XW-OW){head_re[OW-1]}}, head_re});
  assign a_im = $signed({{(XW-OW){head_im[OW-1]}}, head_im});
  assign b_re = $signed({{2{in_re[W-1]}}, in_re});
  assign b_im = $signed({{2{in_im[W-1]}}, in_im});

  assign sum_re = fold(a_re + b_re);
  assign sum_im = fold(a_im + b_im);
  assign dif_re = fold(a_re - b_re);
  assign dif_im = fold(a_im - b_im);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        line_re[i] <= '0;
        line_im[i] <= '0;
      end
      primed <= 1'b0;
    end else if (in_valid) begin
      line_re[0] <= phase ? dif_re : b_re[OW-1:0];
      line_im[0] <= phase ? dif_im : b_im[OW-1:0];
      for (int i = 1; i < DEPTH; i++) begin
        line_re[i] <= line_re[i-1];
        line_im[i] <= line_im[i-1];
      end
      if (phase) primed <= 1'b1;
    end
  end

  assign out_valid = in_valid & (phase | primed);
  assign out_re    = phase ? sum_re : head_re;
  assign out_im    = phase ? sum_im : head_im;
endmodule

// File: rtl/rdf_butterfly_chk.sv
module rdf_butterfly_chk #(
  parameter int W = 16,
  parameter int OW = 17
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 phase,
  input logic signed [W-1:0]  in_re,
  input logic                 out_valid,
  input logic signed [OW-1:0] head_re,
  input logic signed [OW-1:0] tail_re
);
  a_r5_valid_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_valid);

  a_r4_compute_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase) |-> out_valid);

  a_r7_reset_blocks_fill: assert property (@(posedge clk)
    rst |=> (phase || !out_valid));

  a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(head_re));

  a_r1_fill_captures: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !phase) |=> (tail_re == $past(in_re)));
endmodule

bind rdf_butterfly rdf_butterfly_chk #(.W(W), .OW(OW)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase), .in_re(in_re),
  .out_valid(out_valid), .head_re(head_re), .tail_re(line_re[0])
);

// File: tb/rdf_butterfly_test.sv
module rdf_butterfly_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic phase = 1'b0;
  logic signed [7:0] in_re = '0;
  logic signed [7:0] in_im = '0;
  logic o_valid, h_valid;
  logic signed [8:0] o_re, o_im;
  logic signed [7:0] h_re, h_im;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rdf_butterfly #(.W(8), .DEPTH(4), .SCALE(1'b0)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase),
    .in_re(in_re), .in_im(in_im),
    .out_valid(o_valid), .out_re(o_re), .out_im(o_im));

  rdf_butterfly #(.W(8), .DEPTH(4), .SCALE(1'b1)) uut_half (
    .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase),
    .in_re(in_re), .in_im(in_im),
    .out_valid(h_valid), .out_re(h_re), .out_im(h_im));

  // row: phase, in_re, in_im, exp_valid, exp_re, exp_im
  localparam logic [35:0] VEC [20] = '{
    {1'b0, 8'sd10, 8'sd1, 1'b0, 9'sd0, 9'sd0},
    {1'b0, 8'sd20, 8'sd2, 1'b0, 9'sd0, 9'sd0},
    {1'b0, 8'sd30, 8'sd3, 1'b0, 9'sd0, 9'sd0},
    {1'b0, 8'sd40, 8'sd4, 1'b0, 9'sd0, 9'sd0},
    {1'b1, 8'sd1, -8'sd1, 1'b1, 9'sd11, 9'sd0},
    {1'b1, 8'sd2, -8'sd2, 1'b1, 9'sd22, 9'sd0},
    {1'b1, 8'sd3, -8'sd3, 1'b1, 9'sd33, 9'sd0},
    {1'b1, 8'sd4, -8'sd4, 1'b1, 9'sd44, 9'sd0},
    {1'b0, 8'sd5, 8'sd0, 1'b1, 9'sd9, 9'sd2},
    {1'b0, 8'sd6, 8'sd0, 1'b1, 9'sd18, 9'sd4},
    {1'b0, 8'sd7, 8'sd0, 1'b1, 9'sd27, 9'sd6},
    {1'b0, 8'sd8, 8'sd0, 1'b1, 9'sd36, 9'sd8},
    {1'b1, -8'sd5, 8'sd3, 1'b1, 9'sd0, 9'sd3},
    {1'b1, -8'sd6, 8'sd3, 1'b1, 9'sd0, 9'sd3},
    {1'b1, -8'sd7, 8'sd3, 1'b1, 9'sd0, 9'sd3},
    {1'b1, -8'sd8, 8'sd3, 1'b1, 9'sd0, 9'sd3},
    {1'b0, 8'sd0, 8'sd0, 1'b1, 9'sd10, -9'sd3},
    {1'b0, 8'sd0, 8'sd0, 1'b1, 9'sd12, -9'sd3},
    {1'b0, 8'sd0, 8'sd0, 1'b1, 9'sd14, -9'sd3},
    {1'b0, 8'sd0, 8'sd0, 1'b1, 9'sd16, -9'sd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic ph, input int re, input int im);
    @(negedge clk);
    in_valid = v;
    phase = ph;
    in_re = 8'(re);
    in_im = 8'(im);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R7 reset out_valid", int'(o_valid), 0);
    chk("R5 no valid without input", int'(o_valid), 0);
    rst = 1'b0;

    // table: R1 R2 R3 R4
    for (int k = 0; k < 20; k++) begin
      step(1'b1, VEC[k][35], int'($signed(VEC[k][34:27])), int'($signed(VEC[k][26:19])));
      chk(k < 4 ? "R4 first-frame fill invalid" : "R4 valid", int'(o_valid), int'(VEC[k][18]));
      if (VEC[k][18]) begin
        chk(VEC[k][35] ? "R2 sum re" : "R3 drained diff re", int'(o_re), int'($signed(VEC[k][17:9])));
        chk(VEC[k][35] ? "R2 sum im" : "R3 drained diff im", int'(o_im), int'($signed(VEC[k][8:0])));
      end
    end

    // R9 full-scale growth
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 127, -128);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, -128, 127);
      chk("R9 sum re", int'(o_re), -1);
      chk("R9 sum im", int'(o_im), -1);
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 0, 0);
      chk("R9 diff re", int'(o_re), 255);
      chk("R9 diff im", int'(o_im), -255);
    end

    // R6 stall mid-frame
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, k + 1, 0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, k[0], 99, 99);
      chk("R5 stalled valid", int'(o_valid), 0);
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, 10, 0);
      chk("R6 after stall", int'(o_re), 11 + k);
    end

    // R7 reset mid-frame
    do_reset();
    step(1'b1, 1'b0, 7, 7);
    step(1'b1, 1'b0, 7, 7);
    do_reset();
    step(1'b1, 1'b0, 1, 1);
    chk("R7 fill invalid after reset", int'(o_valid), 0);
    do_reset();
    step(1'b1, 1'b1, 5, 5);
    chk("R7 cleared line valid", int'(o_valid), 1);
    chk("R7 cleared line re", int'(o_re), 5);
    chk("R7 cleared line im", int'(o_im), 5);

    // R8 halving with rounding
    do_reset();
    step(1'b1, 1'b0, 3, 0);
    step(1'b1, 1'b0, -3, 0);
    step(1'b1, 1'b0, 1, 0);
    step(1'b1, 1'b0, -1, 0);
    step(1'b1, 1'b1, 0, 0);  chk("R8 sum 3", int'(h_re), 2);
    step(1'b1, 1'b1, 0, 0);  chk("R8 sum -3", int'(h_re), -1);
    step(1'b1, 1'b1, 2, 0);  chk("R8 sum 3b", int'(h_re), 2);
    step(1'b1, 1'b1, -2, 0); chk("R8 sum -3b", int'(h_re), -1);
    step(1'b1, 1'b0, 0, 0);  chk("R8 diff 3", int'(h_re), 2);
    step(1'b1, 1'b0, 0, 0);  chk("R8 diff -3", int'(h_re), -1);
    step(1'b1, 1'b0, 0, 0);  chk("R8 diff -1", int'(h_re), 0);
    step(1'b1, 1'b0, 0, 0);  chk("R8 diff 1", int'(h_re), 1);
    chk("R8 valid", int'(h_valid), 1);

    step(1'b0, 1'b0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule